// File: doc/BRIEF.md
# MDIO Single-Command Management Controller

This block runs one Clause 22 management transaction on an MDC/MDIO pin pair for each command that software writes. Software talks to it through a small 32-bit register port: a command register that both launches a transaction and reports that it is in flight, a data register, and a status register. For a write, software first loads the 16-bit value into the low half of the data register. It then writes the command word with the start flag, one operation bit, the PHY address and the register address.

While the frame is on the wire, the start flag reads back as a busy flag. Every register write is ignored until the frame ends and the flag clears. For a read, the 16 received bits appear in the upper half of the data register. A status bit reports a failed read, which means the PHY did not pull the second turnaround bit low.

MDC comes from a parameterised divider of the system clock and is held low while idle. MDIO output changes on the falling MDC edge and input is sampled on the rising edge. The bidirectional pin is split into output, output-enable and input.

Top module: `mdio_cmd_ctrl`

## Requirements
- R1: After reset, the command, data and status registers read as zero, and MDC and MDIO output-enable are low.
- R2: Register 0 is the command word. Bit 20 is start/busy, bit 17 selects a read, bit 16 selects a write, bits 12:8 hold the PHY address and bits 4:0 hold the register address. After an accepted command, bit 20 reads 1 until the frame ends and then reads 0, and the other fields read back the accepted values.
- R3: A command write is ignored unless bit 20 is set and exactly one of bits 17 and 16 is set. An ignored command leaves busy at 0 and MDC idle.
- R4: While busy, writes to the command and data registers are ignored: the frame in flight and the data register low half are unaffected.
- R5: Each frame is 64 bits, MSB first: 32 ones, start 01, opcode 10 for read or 01 for write, 5-bit PHY address, 5-bit register address, turnaround, then 16 data bits. For a write the turnaround is 10 and output-enable is high for all 64 bits.
- R6: MDC has a period of 2*HALF_DIV system clocks during a frame and is low when idle. The MDIO output changes only on a falling MDC edge.
- R7: During a read, output-enable is high for the first 46 bits and low for the 2 turnaround bits and the 16 data bits.
- R8: Register 1 is the data register. On read completion, bits 31:16 hold the 16 bits sampled during the data phase, MSB first. Bits 15:0 keep the software-written value, and writes to bits 31:16 are ignored.
- R9: Register 2 bit 0 is set at the end of a read whose second turnaround bit was sampled high, and cleared at the end of a read where it was sampled low. Write frames leave it unchanged.
- R10: A write frame carries data register bits 15:0 as its data field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 2 | Register select: 0 command, 1 data, 2 status |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
A pin-level PHY model captures every frame, and the bench goes after the corner cases of the hand-off between software and the engine. It writes a second command and new data in the middle of a frame; a design that let these through would corrupt the frame on the wire or the data register. It sends malformed commands with both or neither operation bit, which a careless decoder would launch as garbage frames. It also exercises reads whose turnaround is pulled high. A design that sampled the wrong turnaround bit, or released output-enable one bit late or early, would report the wrong status or fight the PHY on the bus. Randomised addresses, data and responses check the bit order of every field.

// File: rtl/mdio_cmd_pkg.sv
// Package: shared constants and frame builder for the MDIO command controller.
// Assumes Clause 22 framing only; frame width is fixed by the protocol.
package mdio_cmd_pkg;

    localparam int FRAME_BITS = 64;
    localparam int PRE_BITS   = 32;
    localparam int TA_FIRST   = 46;   // index of the first turnaround bit
    localparam int TA_LAST    = 47;   // index of the bit the PHY must pull low
    localparam int DATA_W     = 16;
    localparam int FIELD_W    = 5;

    localparam int CMD_BUSY_BIT = 20;
    localparam int CMD_RD_BIT   = 17;
    localparam int CMD_WR_BIT   = 16;
    localparam int CMD_PHY_LSB  = 8;
    localparam int CMD_REG_LSB  = 0;

    typedef enum logic [1:0] {
        SEL_CMD  = 2'd0,
        SEL_DATA = 2'd1,
        SEL_STAT = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    // Assemble the 64-bit serial frame, MSB transmitted first.
    function automatic logic [FRAME_BITS-1:0] build_frame(
        input logic               is_rd,
        input logic [FIELD_W-1:0] phy,
        input logic [FIELD_W-1:0] regad,
        input logic [DATA_W-1:0]  wdata
    );
        logic [1:0] op;
        logic [1:0] ta;
        op = is_rd ? 2'b10 : 2'b01;
        ta = is_rd ? 2'b00 : 2'b10;
        return {{PRE_BITS{1'b1}}, 2'b01, op, phy, regad, ta,
                (is_rd ? {DATA_W{1'b0}} : wdata)};
    endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
// Module: MDC generator. Divides the system clock by 2*HALF_DIV while run is
// high and flags the cycle before each MDC rise and fall. Assumes HALF_DIV >= 1.
// MDC is forced low and the phase counter cleared while run is low.
module mdio_mdc_gen #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [CNT_W-1:0] cnt;
    logic             wrap;

    assign wrap      = run && (cnt == CNT_W'(HALF_DIV - 1));
    assign rise_tick = wrap && !mdc;
    assign fall_tick = wrap && mdc;

    // Phase counter and MDC toggle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            mdc <= !mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assert_tick_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_tick && fall_tick));

endmodule

// File: rtl/mdio_frame_engine.sv
// Module: serial frame engine. On start it loads one Clause 22 frame, shifts it
// out on fall ticks and samples MDIO on rise ticks. After the 64th bit it
// pulses done. Assumes rise and fall ticks alternate and rise comes first.
module mdio_frame_engine
    import mdio_cmd_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               start_rd,
    input  logic [FIELD_W-1:0] start_phy,
    input  logic [FIELD_W-1:0] start_reg,
    input  logic [DATA_W-1:0]  start_wdata,
    input  logic               rise_tick,
    input  logic               fall_tick,
    input  logic               mdio_i,
    output logic               busy,
    output logic               done,
    output logic [DATA_W-1:0]  rx_data,
    output logic               ta_bad,
    output logic               mdio_o,
    output logic               mdio_oe
);
    localparam int IDX_W = $clog2(FRAME_BITS);

    logic [FRAME_BITS-1:0] tx_sr;
    logic [IDX_W-1:0]      bit_idx;
    logic                  rd_q;
    logic                  last_bit;

    assign last_bit = (bit_idx == IDX_W'(FRAME_BITS - 1));
    assign done     = busy && fall_tick && last_bit;
    assign mdio_o   = tx_sr[FRAME_BITS-1];
    assign mdio_oe  = busy && (!rd_q || (bit_idx < IDX_W'(TA_FIRST)));

    // Frame sequencing: load, shift on MDC fall, finish after the last bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            rd_q    <= 1'b0;
            tx_sr   <= '0;
            bit_idx <= '0;
        end else if (!busy) begin
            if (start) begin
                busy    <= 1'b1;
                rd_q    <= start_rd;
                tx_sr   <= build_frame(start_rd, start_phy, start_reg, start_wdata);
                bit_idx <= '0;
            end
        end else if (fall_tick) begin
            if (last_bit) begin
                busy  <= 1'b0;
                tx_sr <= '0;
            end else begin
                tx_sr   <= tx_sr << 1;
                bit_idx <= bit_idx + 1'b1;
            end
        end
    end

    // Receive path: sample MDIO on MDC rise, keep the turnaround verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data <= '0;
            ta_bad  <= 1'b0;
        end else if (!busy && start) begin
            ta_bad <= 1'b0;
        end else if (busy && rise_tick) begin
            rx_data <= {rx_data[DATA_W-2:0], mdio_i};
            if (rd_q && bit_idx == IDX_W'(TA_LAST))
                ta_bad <= mdio_i;
        end
    end

    assert_oe_only_at_launch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdio_oe) |-> $rose(busy));

    assert_done_ends_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

endmodule

// File: rtl/mdio_cmd_ctrl.sv
// Module: top of the MDIO single-command controller. Decodes the register
// port, launches one frame per accepted command and collects the read results.
// Assumes register reads are combinational and writes take effect at the clock edge.
module mdio_cmd_ctrl
    import mdio_cmd_pkg::*;
#(
    parameter int HALF_DIV = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  reg_addr,
    input  logic        reg_wr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic               busy;
    logic               done;
    logic               rise_tick;
    logic               fall_tick;
    logic [DATA_W-1:0]  rx_data;
    logic               ta_bad;
    logic               cmd_go;
    logic               op_legal;
    logic               data_wr;
    reg_sel_e           sel;

    logic [FIELD_W-1:0] phy_q;
    logic [FIELD_W-1:0] regad_q;
    logic               rd_q;
    logic               wr_q;
    logic [DATA_W-1:0]  data_lo;
    logic [DATA_W-1:0]  data_hi;
    logic               stat_bad;
    logic               wdata_unused;

    assign sel          = reg_sel_e'(reg_addr);
    assign op_legal     = reg_wdata[CMD_RD_BIT] ^ reg_wdata[CMD_WR_BIT];
    assign cmd_go       = reg_wr && (sel == SEL_CMD) && reg_wdata[CMD_BUSY_BIT]
                          && op_legal && !busy;
    assign data_wr      = reg_wr && (sel == SEL_DATA) && !busy;
    assign wdata_unused = ^{reg_wdata[31:21], reg_wdata[19:18], reg_wdata[15:13],
                            reg_wdata[7:5]};

    // Command fields held for readback.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phy_q   <= '0;
            regad_q <= '0;
            rd_q    <= 1'b0;
            wr_q    <= 1'b0;
        end else if (cmd_go) begin
            phy_q   <= reg_wdata[CMD_PHY_LSB +: FIELD_W];
            regad_q <= reg_wdata[CMD_REG_LSB +: FIELD_W];
            rd_q    <= reg_wdata[CMD_RD_BIT];
            wr_q    <= reg_wdata[CMD_WR_BIT];
        end
    end

    // Data register: software half and received half.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_lo <= '0;
            data_hi <= '0;
        end else begin
            if (data_wr)
                data_lo <= reg_wdata[DATA_W-1:0];
            if (done && rd_q)
                data_hi <= rx_data;
        end
    end

    // Read status: updated at the end of each read frame.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stat_bad <= 1'b0;
        else if (done && rd_q)
            stat_bad <= ta_bad;
    end

    // Register read mux.
    always_comb begin
        reg_rdata = '0;
        case (sel)
            SEL_CMD: begin
                reg_rdata[CMD_BUSY_BIT]               = busy;
                reg_rdata[CMD_RD_BIT]                 = rd_q;
                reg_rdata[CMD_WR_BIT]                 = wr_q;
                reg_rdata[CMD_PHY_LSB +: FIELD_W]     = phy_q;
                reg_rdata[CMD_REG_LSB +: FIELD_W]     = regad_q;
            end
            SEL_DATA: reg_rdata = {data_hi, data_lo};
            SEL_STAT: reg_rdata[0] = stat_bad;
            default:  reg_rdata = '0;
        endcase
    end

    mdio_mdc_gen #(.HALF_DIV(HALF_DIV)) mdc_gen_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (busy),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_frame_engine engine_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (cmd_go),
        .start_rd    (reg_wdata[CMD_RD_BIT]),
        .start_phy   (reg_wdata[CMD_PHY_LSB +: FIELD_W]),
        .start_reg   (reg_wdata[CMD_REG_LSB +: FIELD_W]),
        .start_wdata (data_lo),
        .rise_tick   (rise_tick),
        .fall_tick   (fall_tick),
        .mdio_i      (mdio_i),
        .busy        (busy),
        .done        (done),
        .rx_data     (rx_data),
        .ta_bad      (ta_bad),
        .mdio_o      (mdio_o),
        .mdio_oe     (mdio_oe)
    );

    assert_cmd_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_wr && sel == SEL_CMD) |=> $stable({phy_q, regad_q, rd_q, wr_q}));

    assert_data_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_wr && sel == SEL_DATA) |=> $stable(data_lo));

    assert_one_op_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> $countones({rd_q, wr_q}) == 1);

    assert_mdc_idle_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);

    assert_out_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$stable(mdio_o)) |-> $fell(mdc));

    assert_status_on_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(stat_bad) |-> $past(rd_q));

endmodule

// File: tb/mdio_cmd_ctrl_tb.sv
// Bench: register-level driver plus a pin-level PHY model for mdio_cmd_ctrl.
module mdio_cmd_ctrl_tb_top;
    localparam int HALF = 4;

    logic        clk;
    logic        rst_n;
    logic [1:0]  reg_addr;
    logic        reg_wr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        mdc;
    logic        mdio_o;
    logic        mdio_oe;
    logic        mdio_i;

    int checks;
    int fails;
    int cyc;
    bit finished;

    // PHY model state
    int          phy_bit;
    logic [63:0] cap;
    logic [63:0] oecap;
    logic [15:0] resp;
    bit          bad_ta;
    int          last_rise;
    int          period;

    mdio_cmd_ctrl #(.HALF_DIV(HALF)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .mdc       (mdc),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .mdio_i    (mdio_i)
    );

    initial clk = 1'b0;
    always #5 clk = !clk;

    always @(posedge clk) cyc <= cyc + 1;

    // PHY model: capture on MDC rise.
    always @(posedge mdc) begin
        if (phy_bit < 64) begin
            cap[63 - phy_bit]   = mdio_o;
            oecap[63 - phy_bit] = mdio_oe;
        end
        if (phy_bit > 0) period = cyc - last_rise;
        last_rise = cyc;
        phy_bit = phy_bit + 1;
    end

    // PHY model: drive response after MDC fall.
    always @(negedge mdc) begin
        if (phy_bit == 47)
            mdio_i <= bad_ta;
        else if (phy_bit >= 48 && phy_bit < 64)
            mdio_i <= resp[63 - phy_bit];
        else
            mdio_i <= 1'b1;
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    function automatic logic [31:0] cmd_word(input bit rd, input logic [4:0] phy,
                                             input logic [4:0] ra);
        logic [31:0] w;
        w = 32'h0010_0000;
        w[rd ? 17 : 16] = 1'b1;
        w[12:8] = phy;
        w[4:0]  = ra;
        return w;
    endfunction

    function automatic logic [63:0] exp_frame(input bit rd, input logic [4:0] phy,
                                              input logic [4:0] ra, input logic [15:0] wd);
        return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, ra,
                (rd ? 2'b00 : 2'b10), (rd ? 16'h0 : wd)};
    endfunction

    function automatic logic [63:0] oe_mask(input bit rd);
        return rd ? {{46{1'b1}}, 18'b0} : {64{1'b1}};
    endfunction

    task automatic wait_idle(output bit ok);
        logic [31:0] v;
        ok = 1'b0;
        for (int i = 0; i < 4000; i++) begin
            reg_read(2'd0, v);
            if (!v[20]) begin
                ok = 1'b1;
                break;
            end
        end
    endtask

    // One full transaction with checks; disturb=1 injects writes while busy.
    task automatic run_txn(input bit rd, input logic [4:0] phy, input logic [4:0] ra,
                           input logic [15:0] wd, input logic [15:0] rsp,
                           input bit bad, input bit disturb);
        logic [31:0] v;
        logic [31:0] prev_stat;
        logic [63:0] ef;
        logic [63:0] m;
        bit ok;
        reg_write(2'd1, {16'hA5A5, wd});
        reg_read(2'd2, prev_stat);
        phy_bit = 0;
        resp    = rsp;
        bad_ta  = bad;
        reg_write(2'd0, cmd_word(rd, phy, ra));
        reg_read(2'd0, v);
        chk(v == cmd_word(rd, phy, ra), "R2 busy and fields after launch", 64'(v),
            64'(cmd_word(rd, phy, ra)));
        if (disturb) begin
            reg_write(2'd0, cmd_word(!rd, ~phy, ~ra));
            reg_write(2'd1, {16'h0, ~wd});
            reg_read(2'd0, v);
            chk(v == cmd_word(rd, phy, ra), "R4 command ignored while busy", 64'(v),
                64'(cmd_word(rd, phy, ra)));
        end
        wait_idle(ok);
        chk(ok, "R2 busy clears at frame end", 64'(ok), 64'd1);
        reg_read(2'd0, v);
        chk(v == (cmd_word(rd, phy, ra) & ~32'h0010_0000), "R2 fields after done",
            64'(v), 64'(cmd_word(rd, phy, ra) & ~32'h0010_0000));
        ef = exp_frame(rd, phy, ra, wd);
        m  = oe_mask(rd);
        chk((cap & m) == (ef & m), rd ? "R5 read frame bits" : "R5 R10 write frame bits",
            cap & m, ef & m);
        chk(oecap == m, rd ? "R7 read output enable" : "R5 write output enable", oecap, m);
        chk(period == 2 * HALF, "R6 MDC period", 64'(period), 64'(2 * HALF));
        chk(phy_bit == 64, "R5 frame length", 64'(phy_bit), 64'd64);
        chk(mdc == 1'b0, "R6 MDC low when idle", 64'(mdc), 64'd0);
        reg_read(2'd1, v);
        if (rd)
            chk(v == {rsp, wd}, "R8 read data placement", 64'(v), 64'({rsp, wd}));
        else
            chk(v[15:0] == wd, disturb ? "R4 data kept while busy" : "R10 data kept",
                64'(v[15:0]), 64'(wd));
        reg_read(2'd2, v);
        if (rd)
            chk(v == 32'(bad), "R9 status after read", 64'(v), 64'(bad));
        else
            chk(v == prev_stat, "R9 status unchanged by write", 64'(v), 64'(prev_stat));
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        finish_run();
    end

    initial begin
        logic [31:0] v;
        bit saw_mdc;
        void'($urandom(32'd20240611));
        checks = 0; fails = 0; cyc = 0; finished = 1'b0;
        phy_bit = 0; cap = '0; oecap = '0; resp = '0; bad_ta = 1'b0;
        last_rise = 0; period = 0;
        rst_n = 1'b0; reg_addr = 2'd0; reg_wr = 1'b0; reg_wdata = '0; mdio_i = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        reg_read(2'd0, v); chk(v == 0, "R1 command reset", 64'(v), 64'd0);
        reg_read(2'd1, v); chk(v == 0, "R1 data reset", 64'(v), 64'd0);
        reg_read(2'd2, v); chk(v == 0, "R1 status reset", 64'(v), 64'd0);
        chk(!mdc && !mdio_oe, "R1 pins idle", 64'({mdc, mdio_oe}), 64'd0);

        // R3 malformed commands
        saw_mdc = 1'b0;
        reg_write(2'd0, 32'h0013_0A05);   // both ops
        reg_read(2'd0, v); chk(v == 0, "R3 both ops ignored", 64'(v), 64'd0);
        reg_write(2'd0, 32'h0010_0A05);   // no op
        reg_read(2'd0, v); chk(v == 0, "R3 no op ignored", 64'(v), 64'd0);
        reg_write(2'd0, 32'h0002_0A05);   // op without start
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (mdc) saw_mdc = 1'b1;
        end
        reg_read(2'd0, v); chk(v == 0, "R3 op without start ignored", 64'(v), 64'd0);
        chk(!saw_mdc, "R3 MDC stayed idle", 64'(saw_mdc), 64'd0);

        // Directed corners
        run_txn(1'b0, 5'h1F, 5'h00, 16'hFFFF, 16'h0000, 1'b0, 1'b0);
        run_txn(1'b1, 5'h00, 5'h1F, 16'h1234, 16'h8001, 1'b0, 1'b0);
        run_txn(1'b1, 5'h15, 5'h0A, 16'h00FF, 16'hBEEF, 1'b1, 1'b0);
        run_txn(1'b0, 5'h0A, 5'h15, 16'h8001, 16'h0000, 1'b0, 1'b1);
        run_txn(1'b1, 5'h03, 5'h11, 16'h4321, 16'h5A5A, 1'b0, 1'b1);

        // Randomised transactions
        for (int n = 0; n < 14; n++) begin
            run_txn(1'($urandom), 5'($urandom), 5'($urandom), 16'($urandom),
                    16'($urandom), ($urandom % 4) == 0, ($urandom % 3) == 0);
        end

        finish_run();
    end
endmodule